// File: doc/BRIEF.md
# Multiway Branch Taken-Path Selector

This block resolves one multiway branch. It receives a tree of decoded primitive words, sixteen by default, and the current condition bits. It walks the tree from the root to the single leaf that the condition bits select. The tree is stored depth-first, one word per primitive:

- Tests are skip words. A false outcome falls through to the next word. A true outcome jumps a short distance forward.
- Leaves are unconditional branch words that name the next tree.
- A conditional-branch word is a test whose true side is a leaf, packed into one word.

The walk looks at one word per clock cycle and only ever moves forward. When it reaches a leaf, the block pulses a valid flag and presents two results:

- a commit mask with one bit per buffered word, set only for the ordinary operations that lie on the taken path;
- the target of the leaf that was reached.

Operations on the paths that were not taken get a clear bit, so the execution units discard their results. A walk that leaves the buffer ends with an error flag and commits nothing.

Top module: `tree_path_select`

## Requirements
- R1: While reset is asserted and after it, `result_valid`, `busy`, `walk_error`, `commit_mask` and `next_target` are all zero.
- R2: A `start` sampled high while idle begins a walk at word 0 and raises `busy` on the next cycle. Word i sits at `tree_words[25*i+24 : 25*i]`, with these fields:
  - bits [24:23]: kind, where 00 is operation, 01 is skip, 10 is unconditional branch and 11 is conditional branch;
  - bits [22:20]: condition index c;
  - bits [19:16]: displacement d;
  - bits [15:0]: target.

  A test is true when `cond_bits[c]` is 1.
- R3: After a walk ends at a leaf, `commit_mask` bit i is 1 exactly when word i is an operation the walk visited. Every other bit is 0.
- R4: At a skip word i, a false test continues at word i+1 and a true test continues at word i+d. Condition bits that the visited tests do not name have no effect on the result.
- R5: Reaching an unconditional branch word ends the walk, and `next_target` takes that word's target.
- R6: A conditional-branch word with a true test ends the walk with its own target. With a false test the walk continues at the next word.
- R7: `result_valid` rises exactly N clock edges after the edge that samples `start`, where N is the number of words visited, leaf included. N is at most the buffer depth.
- R8: The walk faults in three cases: it must step past the last word; a true skip has d = 0; or a true skip has i+d beyond the last word. A fault ends the walk with `walk_error` = 1, `commit_mask` = 0 and `next_target` = 0.
- R9: A `start` raised while `busy` is high is ignored. The running walk ends with the same result and latency it would have had without it.
- R10: `result_valid` is high for exactly one cycle. `commit_mask`, `next_target` and `walk_error` hold their values until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk at word 0 when idle |
| tree_words | input | 400 | Sixteen 25-bit decoded words, word 0 in the low bits |
| cond_bits | input | 8 | Condition bits indexed by the test words |
| result_valid | output | 1 | One-cycle pulse when a walk ends |
| busy | output | 1 | A walk is in progress |
| walk_error | output | 1 | The last walk left the buffer or used a bad displacement |
| commit_mask | output | 16 | Operations on the taken path of the last walk |
| next_target | output | 16 | Branch target of the selected leaf |

## Verification
The assertions check four properties on every cycle:
- the walk position only ever increases, so a start during a walk cannot rewind it;
- a walk never runs longer than the buffer depth;
- the commit mask only gains bits during a walk;
- a fault result carries an empty mask and a zero target.

Only the bench's scenarios can show the rest. This covers which leaf a given set of condition bits selects, the exact set of committed operations and the exact latency. It also covers whether unnamed condition bits leave the result unchanged, and how the buffer edges behave: a jump that lands exactly on the last word, or one that lands just past it.

// File: rtl/tps_pkg.sv
package tps_pkg;

  localparam int KIND_W = 2;
  localparam int CF_W   = 3;
  localparam int DISP_W = 4;
  localparam int TGT_W  = 16;
  localparam int WORD_W = KIND_W + CF_W + DISP_W + TGT_W;

  typedef enum logic [KIND_W-1:0] {
    K_OP   = 2'b00,
    K_SKIP = 2'b01,
    K_BR   = 2'b10,
    K_CBR  = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    ACT_COMMIT_NEXT,
    ACT_NEXT,
    ACT_JUMP,
    ACT_LEAF,
    ACT_FAULT
  } step_e;

  typedef enum logic {ST_IDLE, ST_WALK} walk_state_e;

  function automatic kind_e word_kind(input logic [WORD_W-1:0] w);
    return kind_e'(w[WORD_W-1 -: KIND_W]);
  endfunction

  function automatic logic [CF_W-1:0] word_cf(input logic [WORD_W-1:0] w);
    return w[TGT_W+DISP_W +: CF_W];
  endfunction

  function automatic logic [DISP_W-1:0] word_disp(input logic [WORD_W-1:0] w);
    return w[TGT_W +: DISP_W];
  endfunction

  function automatic logic [TGT_W-1:0] word_tgt(input logic [WORD_W-1:0] w);
    return w[TGT_W-1:0];
  endfunction

  // Destination of a taken skip: forward by the displacement.
  function automatic logic [31:0] skip_dest(input logic [31:0] pc,
                                            input logic [DISP_W-1:0] disp);
    return pc + 32'(disp);
  endfunction

  // A taken skip is illegal when it does not move forward or leaves the buffer.
  function automatic logic skip_bad(input logic [31:0] pc,
                                    input logic [DISP_W-1:0] disp,
                                    input logic [31:0] depth);
    return (disp == '0) || (skip_dest(pc, disp) >= depth);
  endfunction

  // Falling through from the last entry leaves the buffer.
  function automatic logic falls_off_end(input logic [31:0] pc,
                                         input logic [31:0] depth);
    return (pc + 32'd1) >= depth;
  endfunction

endpackage

// File: rtl/tps_entry_mux.sv
module tps_entry_mux
  import tps_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH*WORD_W-1:0] words,
  input  logic [IDX_W-1:0]        sel,
  output logic [WORD_W-1:0]       word
);

  logic [WORD_W-1:0] entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
    assign entry[g] = words[g*WORD_W +: WORD_W];
  end

  assign word = entry[sel];

endmodule

// File: rtl/tps_node_eval.sv
module tps_node_eval
  import tps_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int COND_N = 1 << CF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  pc,
  input  logic [COND_N-1:0] cond_bits,
  output step_e             act,
  output logic [IDX_W-1:0]  next_pc,
  output logic [TGT_W-1:0]  leaf_tgt,
  output logic              test_true
);

  localparam logic [31:0] DEPTH_L = 32'(DEPTH);

  kind_e       kind;
  logic [31:0] pc_ext;
  logic [31:0] jump_dest;
  logic        jump_bad;
  logic        off_end;

  always_comb begin
    kind      = word_kind(word);
    test_true = cond_bits[word_cf(word)];
    pc_ext    = 32'(pc);
    jump_dest = skip_dest(pc_ext, word_disp(word));
    jump_bad  = skip_bad(pc_ext, word_disp(word), DEPTH_L);
    off_end   = falls_off_end(pc_ext, DEPTH_L);
    leaf_tgt  = word_tgt(word);

    unique case (kind)
      K_OP:    act = off_end ? ACT_FAULT : ACT_COMMIT_NEXT;
      K_SKIP:  if (test_true) act = jump_bad ? ACT_FAULT : ACT_JUMP;
               else           act = off_end  ? ACT_FAULT : ACT_NEXT;
      K_BR:    act = ACT_LEAF;
      K_CBR:   if (test_true) act = ACT_LEAF;
               else           act = off_end ? ACT_FAULT : ACT_NEXT;
      default: act = ACT_FAULT;
    endcase

    next_pc = (act == ACT_JUMP) ? IDX_W'(jump_dest) : IDX_W'(pc_ext + 32'd1);
  end

  // R4: a taken skip always lands strictly ahead and inside the buffer.
  assert_jump_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && act == ACT_JUMP) |-> (next_pc > pc && 32'(next_pc) < DEPTH));

endmodule

// File: rtl/tps_commit_track.sv
module tps_commit_track #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  output logic [DEPTH-1:0] mask
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    mask[g] <= 1'b0;
      else if (clear)                                mask[g] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(g))       mask[g] <= 1'b1;
    end
  end

  // R3: between clears, committed bits are never withdrawn.
  assert_mask_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((mask & $past(mask)) == $past(mask)));

endmodule

// File: rtl/tree_path_select.sv
module tree_path_select
  import tps_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int COND_N = 1 << CF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DEPTH*WORD_W-1:0] tree_words,
  input  logic [COND_N-1:0]       cond_bits,
  output logic                    result_valid,
  output logic                    busy,
  output logic                    walk_error,
  output logic [DEPTH-1:0]        commit_mask,
  output logic [TGT_W-1:0]        next_target
);

  localparam int IDX_W  = $clog2(DEPTH);
  localparam int STEP_W = $clog2(DEPTH + 1);

  walk_state_e       state_q;
  logic [IDX_W-1:0]  pc_q;
  logic [STEP_W-1:0] steps_q;
  logic              res_valid_q;
  logic              res_err_q;
  logic [DEPTH-1:0]  res_mask_q;
  logic [TGT_W-1:0]  res_tgt_q;

  logic [WORD_W-1:0] cur_word;
  step_e             act;
  logic [IDX_W-1:0]  next_pc;
  logic [TGT_W-1:0]  leaf_tgt;
  logic              test_true;
  logic [DEPTH-1:0]  live_mask;

  // Named events for the assertions and for readability.
  logic walking;
  logic launch;
  logic ev_commit;
  logic ev_leaf;
  logic ev_fault;

  assign walking   = (state_q == ST_WALK);
  assign launch    = (state_q == ST_IDLE) && start;
  assign ev_commit = walking && (act == ACT_COMMIT_NEXT);
  assign ev_leaf   = walking && (act == ACT_LEAF);
  assign ev_fault  = walking && (act == ACT_FAULT);

  tps_entry_mux #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mux (
    .words (tree_words),
    .sel   (pc_q),
    .word  (cur_word)
  );

  tps_node_eval #(.DEPTH(DEPTH), .IDX_W(IDX_W), .COND_N(COND_N)) u_eval (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (walking),
    .word      (cur_word),
    .pc        (pc_q),
    .cond_bits (cond_bits),
    .act       (act),
    .next_pc   (next_pc),
    .leaf_tgt  (leaf_tgt),
    .test_true (test_true)
  );

  tps_commit_track #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (launch),
    .set_en  (ev_commit),
    .set_idx (pc_q),
    .mask    (live_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pc_q        <= '0;
      steps_q     <= '0;
      res_valid_q <= 1'b0;
      res_err_q   <= 1'b0;
      res_mask_q  <= '0;
      res_tgt_q   <= '0;
    end else begin
      res_valid_q <= 1'b0;
      if (launch) begin
        state_q <= ST_WALK;
        pc_q    <= '0;
        steps_q <= '0;
      end else if (walking) begin
        steps_q <= steps_q + 1'b1;
        if (ev_leaf) begin
          state_q     <= ST_IDLE;
          res_valid_q <= 1'b1;
          res_err_q   <= 1'b0;
          res_mask_q  <= live_mask;
          res_tgt_q   <= leaf_tgt;
        end else if (ev_fault) begin
          state_q     <= ST_IDLE;
          res_valid_q <= 1'b1;
          res_err_q   <= 1'b1;
          res_mask_q  <= '0;
          res_tgt_q   <= '0;
        end else begin
          pc_q <= next_pc;
        end
      end
    end
  end

  assign result_valid = res_valid_q;
  assign busy         = walking;
  assign walk_error   = res_err_q;
  assign commit_mask  = res_mask_q;
  assign next_target  = res_tgt_q;

  // R2: a walk only begins from a sampled start.
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R9: while walking the position only increases, so a late start never rewinds it.
  assert_forward_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && $past(walking)) |-> (pc_q > $past(pc_q)));

  // R7: a walk never visits more words than the buffer holds.
  assert_walk_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> (32'(steps_q) < DEPTH));

  // R8: a faulted walk reports nothing to commit and no target.
  assert_fault_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && walk_error) |-> (commit_mask == '0 && next_target == '0));

  // R10: the valid flag is a single-cycle pulse.
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

endmodule

// File: tb/test_tree_path_select.sv
`timescale 1ns/1ps
module test_tree_path_select;

  localparam int DEPTH = 16;
  localparam int WW    = 25;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [DEPTH*WW-1:0] tree = '0;
  logic [7:0]        cond = '0;
  logic              result_valid;
  logic              busy;
  logic              walk_error;
  logic [DEPTH-1:0]  commit_mask;
  logic [15:0]       next_target;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tree_path_select i_tree_path_select (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .tree_words   (tree),
    .cond_bits    (cond),
    .result_valid (result_valid),
    .busy         (busy),
    .walk_error   (walk_error),
    .commit_mask  (commit_mask),
    .next_target  (next_target)
  );

  // Vectors for the base tree: cond, mask, target, error, latency.
  localparam logic [45:0] VECS [0:6] = '{
    {8'h0C, 16'h0015, 16'h00A0, 1'b0, 5'd6},  // c0=0 c1=0 -> A
    {8'hF2, 16'h0005, 16'h00B0, 1'b0, 5'd4},  // c0=0 c1=1 -> B
    {8'h01, 16'h0141, 16'h00C0, 1'b0, 5'd6},  // c0=1 c2=0 -> C
    {8'h0D, 16'h0041, 16'h00D0, 1'b0, 5'd5},  // c0=1 c2=1 c3=1 -> D
    {8'h05, 16'h0841, 16'h00E0, 1'b0, 5'd7},  // c0=1 c2=1 c3=0 -> E
    {8'hFA, 16'h0005, 16'h00B0, 1'b0, 5'd4},  // B, other bits set
    {8'hF3, 16'h0141, 16'h00C0, 1'b0, 5'd6}   // C, other bits set
  };

  function automatic logic [WW-1:0] mk(input logic [1:0] k, input logic [2:0] c,
                                       input logic [3:0] d, input logic [15:0] t);
    return {k, c, d, t};
  endfunction

  task automatic put(input int idx, input logic [WW-1:0] w);
    tree[idx*WW +: WW] = w;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_base();
    tree = '0;
    put(0,  mk(2'b00, 3'd0, 4'd0, 16'h0));
    put(1,  mk(2'b01, 3'd0, 4'd5, 16'h0));
    put(2,  mk(2'b00, 3'd0, 4'd0, 16'h0));
    put(3,  mk(2'b11, 3'd1, 4'd0, 16'h00B0));
    put(4,  mk(2'b00, 3'd0, 4'd0, 16'h0));
    put(5,  mk(2'b10, 3'd0, 4'd0, 16'h00A0));
    put(6,  mk(2'b00, 3'd0, 4'd0, 16'h0));
    put(7,  mk(2'b01, 3'd2, 4'd3, 16'h0));
    put(8,  mk(2'b00, 3'd0, 4'd0, 16'h0));
    put(9,  mk(2'b10, 3'd0, 4'd0, 16'h00C0));
    put(10, mk(2'b11, 3'd3, 4'd0, 16'h00D0));
    put(11, mk(2'b00, 3'd0, 4'd0, 16'h0));
    put(12, mk(2'b10, 3'd0, 4'd0, 16'h00E0));
    put(13, mk(2'b00, 3'd0, 4'd0, 16'h0));
    put(14, mk(2'b00, 3'd0, 4'd0, 16'h0));
    put(15, mk(2'b10, 3'd0, 4'd0, 16'hFFFF));
  endtask

  // Starts a walk; optionally raises start again mid-walk at edge 'restart_at'.
  task automatic walk(input logic [7:0] c, input logic [15:0] em, input logic [15:0] et,
                      input logic ee, input int en, input string tag, input int restart_at);
    int  n = 0;
    bit  seen = 0;
    @(negedge clk);
    cond  = c;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 busy after start"}, 32'(busy), 32'd1);
    while (!seen && n < 40) begin
      if (n == restart_at) start = 1'b1;
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (result_valid) seen = 1;
    end
    chk({tag, " R7 latency"}, 32'(n), 32'(en));
    chk({tag, " R3/R8 mask"}, 32'(commit_mask), 32'(em));
    chk({tag, " R5/R6 target"}, 32'(next_target), 32'(et));
    chk({tag, " R8 error"}, 32'(walk_error), 32'(ee));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid", 32'(result_valid), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mask", 32'(commit_mask), 0);
    chk("R1 target/error", {15'd0, walk_error, next_target}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {30'd0, busy, result_valid}, 0);

    // Table walk over the base tree (R3 R4 R5 R6 R7)
    load_base();
    for (int v = 0; v < 7; v++) begin
      walk(VECS[v][45:38], VECS[v][37:22], VECS[v][21:6], VECS[v][5], int'(VECS[v][4:0]),
           $sformatf("vec%0d R4", v), -1);
    end

    // R10: pulse width and hold of results
    chk("R10 valid drops", 32'(result_valid), 32'd1);
    @(negedge clk);
    chk("R10 valid one cycle", 32'(result_valid), 0);
    repeat (3) @(negedge clk);
    chk("R10 mask held", 32'(commit_mask), 32'h0141);
    chk("R10 target held", 32'(next_target), 32'h00C0);

    // R9: start raised during a walk is ignored
    walk(8'h05, 16'h0841, 16'h00E0, 1'b0, 7, "R9 restart", 2);

    // R8: falling past the last word
    tree = '0;
    walk(8'h00, 16'h0000, 16'h0000, 1'b1, 16, "R8 run-off", -1);

    // R8: skip landing one past the end, taken and not taken
    tree = '0;
    put(3, mk(2'b01, 3'd0, 4'd13, 16'h0));
    put(4, mk(2'b10, 3'd0, 4'd0, 16'h1234));
    walk(8'h01, 16'h0000, 16'h0000, 1'b1, 4, "R8 skip out", -1);
    walk(8'h00, 16'h0007, 16'h1234, 1'b0, 5, "R4 skip false", -1);

    // R8: zero displacement taken
    tree = '0;
    put(0, mk(2'b01, 3'd0, 4'd0, 16'h0));
    put(1, mk(2'b10, 3'd0, 4'd0, 16'h5555));
    walk(8'h01, 16'h0000, 16'h0000, 1'b1, 1, "R8 zero disp", -1);

    // R5: leaf at word 0
    tree = '0;
    put(0, mk(2'b10, 3'd0, 4'd0, 16'hBEEF));
    walk(8'hFF, 16'h0000, 16'hBEEF, 1'b0, 1, "R5 root leaf", -1);

    // R4 R7: jump landing exactly on the last word, longest walk
    tree = '0;
    put(14, mk(2'b01, 3'd7, 4'd1, 16'h0));
    put(15, mk(2'b10, 3'd0, 4'd0, 16'h7777));
    walk(8'h80, 16'h3FFF, 16'h7777, 1'b0, 16, "R4 edge jump", -1);

    // R6: conditional branch on the last word, false -> fault
    tree = '0;
    put(15, mk(2'b11, 3'd2, 4'd0, 16'h4444));
    walk(8'h00, 16'h0000, 16'h0000, 1'b1, 16, "R6 cbr false end", -1);
    walk(8'h04, 16'h7FFF, 16'h4444, 1'b0, 16, "R6 cbr true end", -1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule